// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This unit holds the modem-control register of a 16550-compatible serial port and owns every path that this register steers. It turns two register bits into the active-low DTR and RTS pins. It gates the serial interrupt output with an output-enable bit. It routes serial data and the four modem-status lines either from the package pins or from internal loopback sources. A diagnostic mode lets software send a byte and receive it again inside the port, and exercise the modem-status interrupt from register bits alone.

The effective modem lines are registered into a modem-status register. That register sets a change flag for each line and clears the flags when software reads it. The transmitter, receiver, baud generator and interrupt priority logic sit outside the unit and connect through plain hook-up signals. These are the transmit shift-register output, the receive shift-register input, a combined receive/transmit interrupt request, and the modem-status enable bit of the interrupt enable register. The unit also decodes the low two offsets against the line control register's divisor-latch access bit, so that the neighbouring divisor and data registers can be selected.

Top module: `uart_mdmctl`

## Requirements
- R1: While reset is asserted and after it is released with no write, the control register holds 0: dtr_n_pin and rts_n_pin are 1, irq_oe is 0, loop mode is off and tx_pin follows tx_shift_out.
- R2: The control register sits at offset 4 and is written and read whatever the value of dlab. Bits 4:0 are stored. Bits 7:5 always read 0. With rd_en high, any offset other than 4 and 6 reads 0. With rd_en low, rdata is 0.
- R3: Outside loop mode, dtr_n_pin is the inverse of control bit 0 and rts_n_pin is the inverse of control bit 1. Each follows the register from the clock edge that writes it.
- R4: irq_oe equals control bit 3. irq_o is core_irq OR msr_irq. Control bit 2 reaches no pin.
- R5: When control bit 4 (loop) is 1, tx_pin is 1 and rx_shift_in equals tx_shift_out. When bit 4 is 0, tx_pin equals tx_shift_out and rx_shift_in equals rx_pin.
- R6: In loop mode, dtr_n_pin and rts_n_pin are 1 and the four modem pins are ignored. The internal status lines take CTS from control bit 1, DSR from bit 0, RI from bit 2 and DCD from bit 3.
- R7: Outside loop mode, each status line is the inverse of its active-low pin. The status lines appear in modem-status register bits 7:4 (bit 4 CTS, bit 5 DSR, bit 6 RI, bit 7 DCD) one clock edge after they change. The register is at offset 6.
- R8: Modem-status bits 3:0 are change flags in the order CTS, DSR, RI, DCD. The CTS, DSR and DCD flags set on any change of their line. The RI flag sets only when RI falls from active to inactive. A read at offset 6 clears the flags at that clock edge, but a change detected at the same edge sets its flag anyway.
- R9: msr_irq is 1 exactly when ier_ms_en is 1 and at least one change flag is set.
- R10: With rd_en or wr_en high and offset 0 or 1, dlatch_sel is 1 if dlab is 1 and lowreg_sel is 1 if dlab is 0. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| dlab | input | 1 | Divisor-latch access bit from the line control register |
| rdata | output | 8 | Read data |
| dlatch_sel | output | 1 | Low-offset access aimed at the divisor latches |
| lowreg_sel | output | 1 | Low-offset access aimed at the data and enable registers |
| ier_ms_en | input | 1 | Modem-status interrupt enable |
| core_irq | input | 1 | Receive/transmit interrupt request from neighbouring logic |
| tx_shift_out | input | 1 | Transmit shift-register serial output |
| rx_pin | input | 1 | External serial input |
| cts_n_pin | input | 1 | External clear-to-send, active low |
| dsr_n_pin | input | 1 | External data-set-ready, active low |
| ri_n_pin | input | 1 | External ring indicator, active low |
| dcd_n_pin | input | 1 | External carrier detect, active low |
| tx_pin | output | 1 | External serial output |
| rx_shift_in | output | 1 | Receive shift-register serial input |
| dtr_n_pin | output | 1 | Data-terminal-ready pin, active low |
| rts_n_pin | output | 1 | Request-to-send pin, active low |
| irq_o | output | 1 | Serial interrupt data |
| irq_oe | output | 1 | Serial interrupt output enable |
| msr_irq | output | 1 | Modem-status interrupt request |

## Verification
The bench switches loop mode on and off while the external modem pins toggle. A design that leaked a pin into the status register in loop mode, or left DTR/RTS active there, would return a wrong status nibble or drive a low pin. The RI flag is driven through both a rising and a falling edge of the line. A design that flagged every RI change would report a flag after the rising edge. Reads of the status register overlap line changes, and a second read follows the first. A design that failed to clear the flags, or let the clear win over a fresh change, would leave msr_irq wrong. A write with bits 7:5 set shows whether the upper bits leak into readback.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
  // Status line vector order, shared by the status nibble and the change flags
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;
  localparam int unsigned N_LINES = 4;

  // Control register field positions
  localparam int unsigned CB_DTR  = 0;
  localparam int unsigned CB_RTS  = 1;
  localparam int unsigned CB_AUX  = 2;
  localparam int unsigned CB_IRQE = 3;
  localparam int unsigned CB_LOOP = 4;
  localparam int unsigned CB_USED = 5;

  // Feedback source for each status line in loop mode
  function automatic int unsigned loop_src(int unsigned line);
    case (line)
      LN_CTS:  loop_src = CB_RTS;
      LN_DSR:  loop_src = CB_DTR;
      LN_RI:   loop_src = CB_AUX;
      default: loop_src = CB_IRQE;
    endcase
  endfunction
endpackage

// File: rtl/uart_mcr_reg.sv
module uart_mcr_reg #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFS    = 4,
  parameter int unsigned USED   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mcr_q
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << USED) - 1);

  logic              wr_hit;
  logic [DATA_W-1:0] mcr_d;

  always_comb begin
    wr_hit = wr_en && (addr == ADDR_W'(OFS));
    mcr_d  = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcr_q <= '0;
    end else if (wr_hit) begin
      mcr_q <= mcr_d;
    end
  end
endmodule

// File: rtl/uart_loop_route.sv
module uart_loop_route
  import uart_mdm_pkg::*;
#(
  parameter int unsigned NL = N_LINES,
  parameter int unsigned CW = CB_USED
) (
  input  logic [CW-1:0] ctrl,
  input  logic          tx_shift_out,
  input  logic          rx_pin,
  input  logic [NL-1:0] pins_n,
  output logic          tx_pin,
  output logic          rx_shift_in,
  output logic          dtr_n_pin,
  output logic          rts_n_pin,
  output logic [NL-1:0] line_eff
);
  logic loop_on;
  assign loop_on = ctrl[CB_LOOP];

  always_comb begin
    if (loop_on) begin
      tx_pin      = 1'b1;
      rx_shift_in = tx_shift_out;
      dtr_n_pin   = 1'b1;
      rts_n_pin   = 1'b1;
    end else begin
      tx_pin      = tx_shift_out;
      rx_shift_in = rx_pin;
      dtr_n_pin   = ~ctrl[CB_DTR];
      rts_n_pin   = ~ctrl[CB_RTS];
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_line
    localparam int unsigned SRC = loop_src(i);
    assign line_eff[i] = loop_on ? ctrl[SRC] : ~pins_n[i];
  end
endmodule

// File: rtl/uart_msr_track.sv
module uart_msr_track
  import uart_mdm_pkg::*;
#(
  parameter int unsigned NL = N_LINES,
  parameter int unsigned TRAIL_IDX = LN_RI
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] line_eff,
  input  logic          clr,
  output logic [NL-1:0] state_q,
  output logic [NL-1:0] delta_q
);
  logic [NL-1:0] hit;
  logic [NL-1:0] delta_d;

  for (genvar i = 0; i < NL; i++) begin : g_det
    if (i == TRAIL_IDX) begin : g_trail
      assign hit[i] = state_q[i] & ~line_eff[i];
    end else begin : g_any
      assign hit[i] = state_q[i] ^ line_eff[i];
    end
  end

  always_comb begin
    delta_d = (clr ? '0 : delta_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      delta_q <= '0;
    end else begin
      state_q <= line_eff;
      delta_q <= delta_d;
    end
  end
endmodule

// File: rtl/uart_mdmctl.sv
module uart_mdmctl
  import uart_mdm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MCR_OFS = 4,
  parameter int unsigned MSR_OFS = 6,
  parameter int unsigned LOW_OFS = 2,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dlab,
  output logic [DATA_W-1:0] rdata,
  output logic              dlatch_sel,
  output logic              lowreg_sel,
  input  logic              ier_ms_en,
  input  logic              core_irq,
  input  logic              tx_shift_out,
  input  logic              rx_pin,
  input  logic              cts_n_pin,
  input  logic              dsr_n_pin,
  input  logic              ri_n_pin,
  input  logic              dcd_n_pin,
  output logic              tx_pin,
  output logic              rx_shift_in,
  output logic              dtr_n_pin,
  output logic              rts_n_pin,
  output logic              irq_o,
  output logic              irq_oe,
  output logic              msr_irq
);
  localparam int unsigned NL = N_LINES;

  // Reset: asserted asynchronously, released after SYNC_N edges
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_N-1];

  logic [DATA_W-1:0] mcr_bits;
  logic [NL-1:0]     pins_n;
  logic [NL-1:0]     line_eff;
  logic [NL-1:0]     st_q;
  logic [NL-1:0]     dl_q;
  logic              msr_rd;
  logic              mcr_rd;
  logic              low_acc;

  uart_mcr_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFS    (MCR_OFS),
    .USED   (CB_USED)
  ) u_mcr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .addr  (addr),
    .wr_en (wr_en),
    .wdata (wdata),
    .mcr_q (mcr_bits)
  );

  always_comb begin
    pins_n[LN_CTS] = cts_n_pin;
    pins_n[LN_DSR] = dsr_n_pin;
    pins_n[LN_RI]  = ri_n_pin;
    pins_n[LN_DCD] = dcd_n_pin;
  end

  uart_loop_route #(
    .NL (NL),
    .CW (CB_USED)
  ) u_route (
    .ctrl         (mcr_bits[CB_USED-1:0]),
    .tx_shift_out (tx_shift_out),
    .rx_pin       (rx_pin),
    .pins_n       (pins_n),
    .tx_pin       (tx_pin),
    .rx_shift_in  (rx_shift_in),
    .dtr_n_pin    (dtr_n_pin),
    .rts_n_pin    (rts_n_pin),
    .line_eff     (line_eff)
  );

  uart_msr_track #(
    .NL        (NL),
    .TRAIL_IDX (LN_RI)
  ) u_msr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .line_eff (line_eff),
    .clr      (msr_rd),
    .state_q  (st_q),
    .delta_q  (dl_q)
  );

  // Register read and address decode
  always_comb begin
    mcr_rd     = rd_en && (addr == ADDR_W'(MCR_OFS));
    msr_rd     = rd_en && (addr == ADDR_W'(MSR_OFS));
    low_acc    = (rd_en || wr_en) && (addr < ADDR_W'(LOW_OFS));
    dlatch_sel = low_acc && dlab;
    lowreg_sel = low_acc && !dlab;
    if (mcr_rd)      rdata = mcr_bits;
    else if (msr_rd) rdata = DATA_W'({st_q, dl_q});
    else             rdata = '0;
  end

  // Interrupt output and its enable
  always_comb begin
    msr_irq = ier_ms_en && (|dl_q);
    irq_o   = core_irq || msr_irq;
    irq_oe  = mcr_bits[CB_IRQE];
  end
endmodule

// File: rtl/uart_mdmctl_chk.sv
module uart_mdmctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] mcr_bits,
  input logic       ier_ms_en,
  input logic       tx_shift_out,
  input logic       tx_pin,
  input logic       rx_shift_in,
  input logic       dtr_n_pin,
  input logic       rts_n_pin,
  input logic       irq_oe,
  input logic       msr_irq
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (dtr_n_pin && rts_n_pin && !irq_oe);
    end
  end

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd4) |-> (rdata[7:5] == 3'b000));

  assert_dtr_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && !wdata[4]) |=> (dtr_n_pin == !$past(wdata[0])));

  assert_rts_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && !wdata[4]) |=> (rts_n_pin == !$past(wdata[1])));

  assert_oe_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4) |=> (irq_oe == $past(wdata[3])));

  assert_loop_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_bits[4] |-> (tx_pin && rx_shift_in == tx_shift_out));

  assert_loop_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_bits[4] |-> (dtr_n_pin && rts_n_pin));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_ms_en |-> !msr_irq);
endmodule

bind uart_mdmctl uart_mdmctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .wdata        (wdata),
  .rdata        (rdata),
  .mcr_bits     (mcr_bits),
  .ier_ms_en    (ier_ms_en),
  .tx_shift_out (tx_shift_out),
  .tx_pin       (tx_pin),
  .rx_shift_in  (rx_shift_in),
  .dtr_n_pin    (dtr_n_pin),
  .rts_n_pin    (rts_n_pin),
  .irq_oe       (irq_oe),
  .msr_irq      (msr_irq)
);

// File: tb/uart_mdmctl_bench.sv
module uart_mdmctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       dlab = 1'b0;
  logic [7:0] rdata;
  logic       dlatch_sel, lowreg_sel;
  logic       ier_ms_en = 1'b0, core_irq = 1'b0;
  logic       tx_shift_out = 1'b1, rx_pin = 1'b1;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       tx_pin, rx_shift_in, dtr_n_pin, rts_n_pin, irq_o, irq_oe, msr_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_mdmctl u_uart_mdmctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .dlab(dlab), .rdata(rdata), .dlatch_sel(dlatch_sel),
    .lowreg_sel(lowreg_sel), .ier_ms_en(ier_ms_en), .core_irq(core_irq),
    .tx_shift_out(tx_shift_out), .rx_pin(rx_pin), .cts_n_pin(cts_n),
    .dsr_n_pin(dsr_n), .ri_n_pin(ri_n), .dcd_n_pin(dcd_n), .tx_pin(tx_pin),
    .rx_shift_in(rx_shift_in), .dtr_n_pin(dtr_n_pin), .rts_n_pin(rts_n_pin),
    .irq_o(irq_o), .irq_oe(irq_oe), .msr_irq(msr_irq)
  );

  // Reference state, derived from the requirements
  logic [4:0] mcr_m;
  logic [3:0] st_m, dl_m;

  // Status lines in order CTS, DSR, RI, DCD (bits 0..3)
  function automatic logic [3:0] eff_fn(logic [4:0] m, logic c, logic d, logic r, logic k);
    if (m[4]) eff_fn = {m[3], m[2], m[0], m[1]};
    else      eff_fn = {~k, ~r, ~d, ~c};
  endfunction

  function automatic logic [3:0] flags_fn(logic [3:0] old, logic [3:0] now);
    flags_fn = old ^ now;
    flags_fn[2] = old[2] & ~now[2];
  endfunction

  function automatic logic [7:0] rd_fn(logic rd, logic [2:0] a, logic [4:0] m,
                                       logic [3:0] s, logic [3:0] f);
    if (!rd)          rd_fn = 8'h00;
    else if (a == 3'd4) rd_fn = {3'b000, m};
    else if (a == 3'd6) rd_fn = {s, f};
    else              rd_fn = 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcr_m <= '0; st_m <= '0; dl_m <= '0;
    end else begin
      logic [3:0] e;
      e = eff_fn(mcr_m, cts_n, dsr_n, ri_n, dcd_n);
      dl_m <= ((rd_en && addr == 3'd6) ? 4'h0 : dl_m) | flags_fn(st_m, e);
      st_m <= e;
      if (wr_en && addr == 3'd4) mcr_m <= wdata[4:0];
    end
  end

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic exp_dtr, exp_rts, exp_mirq, sel_low;
    logic [7:0] exp_rd;
    string pin_tag;
    pin_tag = mcr_m[4] ? "R6 pins" : "R3 pins";
    exp_dtr = mcr_m[4] ? 1'b1 : ~mcr_m[0];
    exp_rts = mcr_m[4] ? 1'b1 : ~mcr_m[1];
    chk(dtr_n_pin == exp_dtr, pin_tag, {7'd0, dtr_n_pin}, {7'd0, exp_dtr});
    chk(rts_n_pin == exp_rts, pin_tag, {7'd0, rts_n_pin}, {7'd0, exp_rts});
    chk(tx_pin == (mcr_m[4] ? 1'b1 : tx_shift_out), "R5 tx_pin",
        {7'd0, tx_pin}, {7'd0, mcr_m[4] ? 1'b1 : tx_shift_out});
    chk(rx_shift_in == (mcr_m[4] ? tx_shift_out : rx_pin), "R5 rx_shift_in",
        {7'd0, rx_shift_in}, {7'd0, mcr_m[4] ? tx_shift_out : rx_pin});
    exp_mirq = ier_ms_en && (|dl_m);
    chk(msr_irq == exp_mirq, "R9 msr_irq", {7'd0, msr_irq}, {7'd0, exp_mirq});
    chk(irq_oe == mcr_m[3], "R4 irq_oe", {7'd0, irq_oe}, {7'd0, mcr_m[3]});
    chk(irq_o == (core_irq | exp_mirq), "R4 irq_o", {7'd0, irq_o}, {7'd0, core_irq | exp_mirq});
    exp_rd = rd_fn(rd_en, addr, mcr_m, st_m, dl_m);
    chk(rdata == exp_rd, (rd_en && addr == 3'd6) ? "R7 rdata" : "R2 rdata", rdata, exp_rd);
    sel_low = (rd_en || wr_en) && (addr < 3'd2);
    chk(dlatch_sel == (sel_low && dlab), "R10 dlatch_sel", {7'd0, dlatch_sel}, {7'd0, sel_low && dlab});
    chk(lowreg_sel == (sel_low && !dlab), "R10 lowreg_sel", {7'd0, lowreg_sel}, {7'd0, sel_low && !dlab});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      #1 check_all();
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    #1 check_all();
    @(negedge clk);
    wr_en = 1'b0;
    #1 check_all();
  endtask

  task automatic bus_read(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1 d = rdata;
    check_all();
    @(negedge clk);
    rd_en = 1'b0;
    #1 check_all();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk(dtr_n_pin && rts_n_pin, "R1 reset pins", {6'd0, dtr_n_pin, rts_n_pin}, 8'h03);
    chk(!irq_oe, "R1 reset irq_oe", {7'd0, irq_oe}, 8'h00);
    rst_n = 1'b1;
    idle(5);
    tx_shift_out = 1'b0;
    #1 chk(tx_pin == 1'b0, "R1 tx follows after reset", {7'd0, tx_pin}, 8'h00);
    bus_read(3'd4, v);
    chk(v == 8'h00, "R1 control reads 0", v, 8'h00);

    // R2: upper bits dropped, access independent of dlab
    dlab = 1'b1;
    bus_write(3'd4, 8'hE7);
    bus_read(3'd4, v);
    chk(v == 8'h07, "R2 readback with dlab=1", v, 8'h07);
    dlab = 1'b0;
    bus_write(3'd4, 8'h00);
    idle(2);
    bus_read(3'd6, v);

    // R6/R8: loop with all outputs high, external pins toggled
    bus_write(3'd4, 8'h1F);
    cts_n = 1'b0; dsr_n = 1'b0; ri_n = 1'b0; dcd_n = 1'b0;
    idle(2);
    bus_read(3'd6, v);
    chk(v == 8'hFB, "R6 loop status and R8 flags, no RI flag on rise", v, 8'hFB);
    bus_read(3'd6, v);
    chk(v == 8'hF0, "R8 flags cleared by read", v, 8'hF0);
    bus_write(3'd4, 8'h10);
    idle(2);
    bus_read(3'd6, v);
    chk(v == 8'h0F, "R8 all flags incl RI trailing edge", v, 8'h0F);
    ier_ms_en = 1'b1;
    bus_write(3'd4, 8'h14);
    idle(2);
    #1 chk(msr_irq == 1'b0, "R8 RI rise sets no flag", {7'd0, msr_irq}, 8'h00);
    bus_read(3'd6, v);
    chk(v == 8'h40, "R6 RI from control bit 2", v, 8'h40);
    bus_write(3'd4, 8'h00);
    cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
    idle(2);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      @(negedge clk);
      r = $urandom % 16;
      wr_en = (r < 2);
      rd_en = (r >= 2 && r < 7);
      if (wr_en) addr = ($urandom % 4 != 0) ? 3'd4 : 3'($urandom);
      else if (rd_en) addr = ($urandom % 2 != 0) ? 3'd6 : (($urandom % 2 != 0) ? 3'd4 : 3'($urandom));
      else addr = 3'($urandom);
      wdata = 8'($urandom);
      dlab = 1'($urandom);
      ier_ms_en = ($urandom % 4 != 0);
      core_irq = ($urandom % 8 == 0);
      tx_shift_out = 1'($urandom);
      rx_pin = 1'($urandom);
      if ($urandom % 8 == 0) cts_n = ~cts_n;
      if ($urandom % 8 == 0) dsr_n = ~dsr_n;
      if ($urandom % 8 == 0) ri_n = ~ri_n;
      if ($urandom % 8 == 0) dcd_n = ~dcd_n;
      #1 check_all();
    end
    idle(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule